// File: doc/BRIEF.md
# Transmit Descriptor Ring Run-State Controller

This block decides when a transmit DMA engine walks its descriptor ring. Software raises a level command bit to start the engine and lowers it to stop. While running, the block asks a descriptor fetch port for the entry at the current ring position. If the DMA owns that entry, the block issues a frame-transmit request and waits for completion. It then steps to the next entry.

A fetched entry that the DMA does not own parks the engine in a suspended state and raises a sticky buffer-unavailable flag. The engine leaves that state through a poll pulse, which repeats the check, or through a stop. A stop never cuts a frame short. The ring position survives a stop, so a restart resumes where the walk left off. Writing the base address while the engine is stopped rewinds the position to the new base.

Top module: `txdma_run_ctrl`

## Requirements
- R1: After reset, run_state is 0 (stopped), cur_pos is 0, buf_unavail is 0, and neither fetch_req nor xmit_req is high.
- R2: With run_state 0 and run_cmd high at a clock edge, the next cycle shows run_state 1 (running), with fetch_req high and fetch_addr equal to cur_pos.
- R3: A base_wr pulse while stopped loads cur_pos with base_addr in the next cycle. A base_wr in any other state leaves cur_pos unchanged and only replaces the stored wrap base.
- R4: A completed fetch (fetch_done) with fetch_own high and run_cmd high raises xmit_req until xmit_done. On xmit_done, cur_pos advances by DESC_BYTES and, if run_cmd is still high, the next fetch starts at once.
- R5: When the owned entry was fetched with fetch_ring_end high, its frame completion sets cur_pos to the stored base instead of advancing.
- R6: A completed fetch with fetch_own low and run_cmd high moves run_state to 2 (suspended) and sets buf_unavail. cur_pos is unchanged.
- R7: buf_unavail clears in the cycle after an unavail_clr pulse. If a new unowned fetch completes in the same cycle as the clear, the flag stays set.
- R8: In suspended state with run_cmd high, the engine stays suspended and issues no fetch until poll_demand pulses. A poll_demand then repeats the fetch at the same cur_pos.
- R9: If run_cmd is low when a frame completes, the engine enters stopped state. cur_pos holds the following entry position.
- R10: In suspended state, a low run_cmd moves the engine to stopped state in the next cycle.
- R11: A restart fetches from the position saved at the last stop, not from the base.
- R12: If run_cmd is low when a fetch completes, the engine enters stopped state without raising xmit_req, and cur_pos is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_cmd | input | 1 | Level start (1) / stop (0) command |
| base_wr | input | 1 | Pulse: write ring base address |
| base_addr | input | AW | Ring base address value |
| poll_demand | input | 1 | Pulse: repeat ownership check while suspended |
| unavail_clr | input | 1 | Pulse: write-1-to-clear of buf_unavail |
| fetch_req | output | 1 | Descriptor fetch request, held until fetch_done |
| fetch_addr | output | AW | Address of the descriptor to fetch |
| fetch_done | input | 1 | Fetch complete; ownership and ring-end fields valid |
| fetch_own | input | 1 | Fetched descriptor is owned by the DMA |
| fetch_ring_end | input | 1 | Fetched descriptor is the last in the ring |
| xmit_req | output | 1 | Frame transmit request, held until xmit_done |
| xmit_done | input | 1 | Frame transmit complete |
| cur_pos | output | AW | Current ring position |
| buf_unavail | output | 1 | Sticky transmit-buffer-unavailable flag |
| run_state | output | 2 | 0 stopped, 1 running, 2 suspended |

## Verification
The assertions assume three things about the inputs. fetch_done pulses only while fetch_req is high, and xmit_done pulses only while xmit_req is high. fetch_own and fetch_ring_end are meaningful only in the fetch_done cycle. The bench keeps to these rules by having a single responder raise each done for exactly one cycle, on a request it observes. That responder drives the ownership and ring-end answers as functions of the observed fetch address. The command, poll, clear and base-write inputs are driven away from the clock edge as single-cycle pulses or level changes.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_SEND  = 2'd2,
    PH_PARK  = 2'd3
  } tx_phase_e;

  localparam logic [1:0] RS_STOPPED   = 2'd0;
  localparam logic [1:0] RS_RUNNING   = 2'd1;
  localparam logic [1:0] RS_SUSPENDED = 2'd2;

  function automatic logic [1:0] phase_to_state(input tx_phase_e ph);
    case (ph)
      PH_IDLE:  return RS_STOPPED;
      PH_PARK:  return RS_SUSPENDED;
      default:  return RS_RUNNING;
    endcase
  endfunction

endpackage

// File: rtl/txdma_phase_fsm.sv
module txdma_phase_fsm
  import txdma_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run_cmd,
  input  logic      poll_demand,
  input  logic      fetch_done,
  input  logic      fetch_own,
  input  logic      xmit_done,
  output tx_phase_e phase,
  output logic      ev_fetch_ok,
  output logic      ev_own_miss,
  output logic      ev_frame_end
);

  tx_phase_e phase_d;
  logic      in_fetch, in_send, in_park, in_idle;

  assign in_idle  = (phase == PH_IDLE);
  assign in_fetch = (phase == PH_FETCH);
  assign in_send  = (phase == PH_SEND);
  assign in_park  = (phase == PH_PARK);

  // a fetch that lands after the command dropped is a frame boundary
  assign ev_fetch_ok  = in_fetch && fetch_done && run_cmd && fetch_own;
  assign ev_own_miss  = in_fetch && fetch_done && run_cmd && !fetch_own;
  assign ev_frame_end = in_send && xmit_done;

  always_comb begin
    phase_d = phase;
    if (in_idle) begin
      if (run_cmd) phase_d = PH_FETCH;
    end else if (in_fetch) begin
      if (fetch_done) begin
        if (!run_cmd)      phase_d = PH_IDLE;
        else if (fetch_own) phase_d = PH_SEND;
        else                phase_d = PH_PARK;
      end
    end else if (in_send) begin
      if (xmit_done) phase_d = run_cmd ? PH_FETCH : PH_IDLE;
    end else begin
      if (!run_cmd)         phase_d = PH_IDLE;
      else if (poll_demand) phase_d = PH_FETCH;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_d;
  end

endmodule

// File: rtl/txdma_pos_track.sv
module txdma_pos_track #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          base_wr,
  input  logic [AW-1:0] base_addr,
  input  logic          stopped,
  input  logic          ev_fetch_ok,
  input  logic          ring_end,
  input  logic          ev_frame_end,
  output logic [AW-1:0] cur_pos
);

  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  logic [AW-1:0] base_q;
  logic          wrap_q;

  function automatic logic [AW-1:0] next_slot(
    input logic [AW-1:0] pos,
    input logic [AW-1:0] base,
    input logic          wrap
  );
    return wrap ? base : pos + STEP;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      wrap_q  <= 1'b0;
      cur_pos <= '0;
    end else begin
      if (base_wr) base_q <= base_addr;
      if (ev_fetch_ok) wrap_q <= ring_end;
      if (ev_frame_end)
        cur_pos <= next_slot(cur_pos, base_q, wrap_q);
      else if (base_wr && stopped)
        cur_pos <= base_addr;
    end
  end

endmodule

// File: rtl/txdma_unavail_flag.sv
module txdma_unavail_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_evt,
  output logic flag
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (set_evt) flag <= 1'b1;
    else if (clr_evt) flag <= 1'b0;
  end

endmodule

// File: rtl/txdma_run_ctrl.sv
module txdma_run_ctrl
  import txdma_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_cmd,
  input  logic          base_wr,
  input  logic [AW-1:0] base_addr,
  input  logic          poll_demand,
  input  logic          unavail_clr,
  output logic          fetch_req,
  output logic [AW-1:0] fetch_addr,
  input  logic          fetch_done,
  input  logic          fetch_own,
  input  logic          fetch_ring_end,
  output logic          xmit_req,
  input  logic          xmit_done,
  output logic [AW-1:0] cur_pos,
  output logic          buf_unavail,
  output logic [1:0]    run_state
);

  tx_phase_e phase;
  logic      ev_fetch_ok, ev_own_miss, ev_frame_end;
  logic      is_stopped;

  txdma_phase_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_cmd      (run_cmd),
    .poll_demand  (poll_demand),
    .fetch_done   (fetch_done),
    .fetch_own    (fetch_own),
    .xmit_done    (xmit_done),
    .phase        (phase),
    .ev_fetch_ok  (ev_fetch_ok),
    .ev_own_miss  (ev_own_miss),
    .ev_frame_end (ev_frame_end)
  );

  assign is_stopped = (phase == PH_IDLE);

  txdma_pos_track #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_pos (
    .clk          (clk),
    .rst_n        (rst_n),
    .base_wr      (base_wr),
    .base_addr    (base_addr),
    .stopped      (is_stopped),
    .ev_fetch_ok  (ev_fetch_ok),
    .ring_end     (fetch_ring_end),
    .ev_frame_end (ev_frame_end),
    .cur_pos      (cur_pos)
  );

  txdma_unavail_flag u_flag (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (ev_own_miss),
    .clr_evt (unavail_clr),
    .flag    (buf_unavail)
  );

  assign fetch_req  = (phase == PH_FETCH);
  assign xmit_req   = (phase == PH_SEND);
  assign fetch_addr = cur_pos;
  assign run_state  = phase_to_state(phase);

endmodule

// File: rtl/txdma_run_ctrl_chk.sv
module txdma_run_ctrl_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run_cmd,
  input logic          base_wr,
  input logic          poll_demand,
  input logic          unavail_clr,
  input logic          fetch_req,
  input logic          xmit_req,
  input logic [AW-1:0] cur_pos,
  input logic          buf_unavail,
  input logic [1:0]    run_state,
  input logic          ev_own_miss,
  input logic          ev_frame_end
);

  // R2
  start_fetches_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'd0 && run_cmd) |=> (fetch_req && run_state == 2'd1));

  // R4
  one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_req, xmit_req}));

  // R3
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_wr && run_state != 2'd0 && !ev_frame_end) |=> $stable(cur_pos));

  // R6
  miss_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_own_miss |=> (run_state == 2'd2 && buf_unavail));

  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (unavail_clr && !ev_own_miss) |=> !buf_unavail);

  // R8
  park_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'd2 && run_cmd && !poll_demand) |=> (run_state == 2'd2 && !fetch_req));

  // R9
  frame_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_frame_end && !run_cmd) |=> (run_state == 2'd0));

  // R10
  park_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_state == 2'd2 && !run_cmd) |=> (run_state == 2'd0));

endmodule

bind txdma_run_ctrl txdma_run_ctrl_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .run_cmd      (run_cmd),
  .base_wr      (base_wr),
  .poll_demand  (poll_demand),
  .unavail_clr  (unavail_clr),
  .fetch_req    (fetch_req),
  .xmit_req     (xmit_req),
  .cur_pos      (cur_pos),
  .buf_unavail  (buf_unavail),
  .run_state    (run_state),
  .ev_own_miss  (ev_own_miss),
  .ev_frame_end (ev_frame_end)
);

// File: tb/test_txdma_run_ctrl.sv
module test_txdma_run_ctrl;

  localparam int AW = 32;
  localparam logic [AW-1:0] NONE = '1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_cmd = 1'b0;
  logic          base_wr = 1'b0;
  logic [AW-1:0] base_addr = '0;
  logic          poll_demand = 1'b0;
  logic          unavail_clr = 1'b0;
  logic          fetch_req;
  logic [AW-1:0] fetch_addr;
  logic          fetch_done = 1'b0;
  logic          fetch_own = 1'b0;
  logic          fetch_ring_end = 1'b0;
  logic          xmit_req;
  logic          xmit_done = 1'b0;
  logic [AW-1:0] cur_pos;
  logic          buf_unavail;
  logic [1:0]    run_state;

  int checks = 0;
  int fails = 0;
  int fetches = 0;
  int frames = 0;
  int xcnt = 0;
  int cycles = 0;
  logic [AW-1:0] exp_q[$];
  logic [AW-1:0] hole_addr = NONE;
  logic [AW-1:0] ring_end_addr = NONE;
  logic clr_on_done = 1'b0;
  logic stop_on_done = 1'b0;

  always #4 clk = ~clk;

  txdma_run_ctrl #(.AW(AW), .DESC_BYTES(16)) i_txdma_run_ctrl (
    .clk(clk), .rst_n(rst_n), .run_cmd(run_cmd), .base_wr(base_wr),
    .base_addr(base_addr), .poll_demand(poll_demand), .unavail_clr(unavail_clr),
    .fetch_req(fetch_req), .fetch_addr(fetch_addr), .fetch_done(fetch_done),
    .fetch_own(fetch_own), .fetch_ring_end(fetch_ring_end), .xmit_req(xmit_req),
    .xmit_done(xmit_done), .cur_pos(cur_pos), .buf_unavail(buf_unavail),
    .run_state(run_state)
  );

  task automatic chk(input logic ok, input string tag, input logic [AW-1:0] act,
                     input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic expect_fetch(input logic [AW-1:0] a);
    exp_q.push_back(a);
  endtask

  task automatic write_base(input logic [AW-1:0] a);
    base_addr = a;
    base_wr = 1'b1;
    @(negedge clk);
    base_wr = 1'b0;
  endtask

  // scoreboard monitor and descriptor/frame responder
  always @(negedge clk) begin
    if (rst_n) begin
      if (fetch_req && !fetch_done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected fetch", fetch_addr, '0);
        end else begin
          logic [AW-1:0] e;
          e = exp_q.pop_front();
          chk(fetch_addr == e, "R4 R5 R11 fetch address", fetch_addr, e);
        end
        fetch_done = 1'b1;
        fetch_own = (fetch_addr != hole_addr);
        fetch_ring_end = (fetch_addr == ring_end_addr);
        fetches++;
        if (clr_on_done) unavail_clr = 1'b1;
        if (stop_on_done) run_cmd = 1'b0;
      end else begin
        fetch_done = 1'b0;
        if (clr_on_done) unavail_clr = 1'b0;
      end
      if (xmit_req && !xmit_done) begin
        xcnt++;
        if (xcnt >= 2) begin
          xmit_done = 1'b1;
          xcnt = 0;
          frames++;
        end
      end else begin
        xmit_done = 1'b0;
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int f0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(run_state == 2'd0, "R1 state", AW'(run_state), 0);
    chk(cur_pos == 0, "R1 cur_pos", cur_pos, 0);
    chk(!buf_unavail && !fetch_req && !xmit_req, "R1 outputs",
        AW'({buf_unavail, fetch_req, xmit_req}), 0);

    // R3 base write while stopped
    write_base(32'h1000);
    chk(cur_pos == 32'h1000, "R3 load while stopped", cur_pos, 32'h1000);

    // R4 R5 walk with wrap, R9 stop mid-frame
    ring_end_addr = 32'h1020;
    expect_fetch(32'h1000); expect_fetch(32'h1010);
    expect_fetch(32'h1020); expect_fetch(32'h1000);
    run_cmd = 1'b1;
    while (!(fetches == 4 && xmit_req)) @(negedge clk);
    run_cmd = 1'b0;
    while (run_state != 2'd0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(frames == 4, "R9 frame finished", AW'(frames), 4);
    chk(cur_pos == 32'h1010, "R9 saved next position", cur_pos, 32'h1010);
    chk(exp_q.size() == 0, "R9 no fetch after stop", AW'(exp_q.size()), 0);

    // R11 restart from saved position, R6 unowned descriptor
    hole_addr = 32'h1020;
    expect_fetch(32'h1010); expect_fetch(32'h1020);
    run_cmd = 1'b1;
    while (fetches < 6) @(negedge clk);
    @(negedge clk);
    chk(run_state == 2'd2, "R6 suspended", AW'(run_state), 2);
    chk(buf_unavail, "R6 flag set", AW'(buf_unavail), 1);
    chk(cur_pos == 32'h1020, "R6 position held", cur_pos, 32'h1020);

    // R3 base write while suspended, R8 no fetch without poll
    write_base(32'h3000);
    chk(cur_pos == 32'h1020, "R3 no load while suspended", cur_pos, 32'h1020);
    f0 = fetches;
    repeat (4) @(negedge clk);
    chk(run_state == 2'd2 && fetches == f0, "R8 stays suspended",
        AW'(run_state), 2);

    // R7 clear
    unavail_clr = 1'b1;
    @(negedge clk);
    unavail_clr = 1'b0;
    chk(!buf_unavail, "R7 cleared", AW'(buf_unavail), 0);

    // R8 poll refetch, R7 set wins over clear
    clr_on_done = 1'b1;
    expect_fetch(32'h1020);
    poll_demand = 1'b1;
    @(negedge clk);
    poll_demand = 1'b0;
    while (fetches < f0 + 1) @(negedge clk);
    @(negedge clk);
    clr_on_done = 1'b0;
    unavail_clr = 1'b0;
    chk(buf_unavail, "R7 set wins", AW'(buf_unavail), 1);
    chk(run_state == 2'd2, "R8 refetch suspends again", AW'(run_state), 2);

    // R5 wrap to updated base, then R10 stop from suspended
    hole_addr = 32'h3000;
    expect_fetch(32'h1020); expect_fetch(32'h3000);
    poll_demand = 1'b1;
    @(negedge clk);
    poll_demand = 1'b0;
    while (fetches < f0 + 3) @(negedge clk);
    @(negedge clk);
    chk(run_state == 2'd2, "R6 suspended at new base", AW'(run_state), 2);
    chk(cur_pos == 32'h3000, "R5 wrapped to base", cur_pos, 32'h3000);
    run_cmd = 1'b0;
    @(negedge clk);
    chk(run_state == 2'd0, "R10 stop from suspended", AW'(run_state), 0);

    // R2 start timing, R12 stop at fetch boundary
    hole_addr = NONE;
    stop_on_done = 1'b1;
    f0 = frames;
    expect_fetch(32'h3000);
    run_cmd = 1'b1;
    @(negedge clk);
    chk(fetch_req && fetch_addr == 32'h3000, "R2 fetch after start",
        fetch_addr, 32'h3000);
    repeat (4) @(negedge clk);
    stop_on_done = 1'b0;
    chk(run_state == 2'd0, "R12 stopped", AW'(run_state), 0);
    chk(frames == f0, "R12 no frame", AW'(frames), AW'(f0));
    chk(cur_pos == 32'h3000, "R12 position kept", cur_pos, 32'h3000);

    // R3 reload while stopped
    write_base(32'h4000);
    chk(cur_pos == 32'h4000, "R3 reload", cur_pos, 32'h4000);
    chk(exp_q.size() == 0, "R4 all expected fetches seen", AW'(exp_q.size()), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule